// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block tracks the fetch status of each hardware thread in a multithreaded front end. Each thread holds one of nine states and four sticky stall flags, one per downstream stage (decode, rename, execute, commit). Every cycle the controller takes in the stages' block and unblock pulses, squash requests from commit and decode, a flag saying the reorder buffer is still squashing, and a global context-switch flag. It then moves each thread to its next state by a fixed priority and reports whether any thread's status changed.

The cache request logic owns the cache-wait and completion states. It writes them into a thread through a per-thread load strobe, and that value becomes the base state for the same cycle's evaluation. When a squash takes effect, the controller returns a per-thread cancel pulse so that any outstanding request of that thread can be dropped. A stage-level active flag is re-evaluated only in cycles that reported a change. All interfaces are plain control and status pins with no handshake, because every input is a one-cycle pulse or a level that the controller samples on each clock.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset every thread is Running (code 0) with all four stall flags clear, `stage_active` is 1, and `status_changed` and `squash_cancel` are 0.
- R2: A stage's stall flag is set by its block pulse and stays set until that stage's unblock pulse. A thread counts as stalled if any of its flags (including one set in the current cycle) is set, or if `ctx_switch` is 1. Block bit order is decode, rename, execute, commit on separate ports.
- R3: A commit squash has top priority. The thread goes to Squashing (code 2), a change is reported, and `squash_cancel` pulses for that thread.
- R4: Failing R3, a raised `rob_squashing` holds or puts the thread in Squashing with a change reported and no cancel pulse. It takes precedence over a decode squash.
- R5: Failing R3 and R4, a decode squash moves the thread to Squashing with a change and a cancel pulse, but only if the thread's base state is not already Squashing. Otherwise evaluation continues with the lower priorities.
- R6: Failing the squashes, a stalled thread goes to Blocked (code 3) with a change, unless its base state is WaitResponse (code 4) or WaitRetry (code 5), which are held with no change.
- R7: With no squash and no stall, a thread whose base state is Blocked or Squashing returns to Running and reports a change.
- R8: Any other base state is kept with no change reported: Idle 1, AccessDone 6, TrapPending 7, QuiescePending 8, plus Running. A load strobe replaces the base state with the loaded code without itself reporting a change.
- R9: `stage_active` is updated only in cycles that report a change. It becomes 1 if any active thread's new state is Running, Squashing or AccessDone, and 0 otherwise.
- R10: A thread whose `thread_active` bit is 0 keeps its state, ignoring squash, stall and load inputs.
- R11: An unblock pulse never coincides with the same stage's block pulse and arrives only while that flag is set. Unblocking clears the stall so the thread recovers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_active | input | NT | Threads taking part in evaluation |
| dec_block | input | NT | Decode block pulse per thread |
| dec_unblock | input | NT | Decode unblock pulse per thread |
| ren_block | input | NT | Rename block pulse per thread |
| ren_unblock | input | NT | Rename unblock pulse per thread |
| exe_block | input | NT | Execute block pulse per thread |
| exe_unblock | input | NT | Execute unblock pulse per thread |
| cmt_block | input | NT | Commit block pulse per thread |
| cmt_unblock | input | NT | Commit unblock pulse per thread |
| cmt_squash | input | NT | Squash request from commit |
| rob_squashing | input | NT | Reorder buffer still squashing |
| dec_squash | input | NT | Squash request from decode |
| ctx_switch | input | 1 | Context switch in progress (stalls all threads) |
| st_load | input | NT | Load strobe for the thread state |
| st_load_val | input | NT*4 | State code to load, 4 bits per thread |
| thread_state | output | NT*4 | Current state code, 4 bits per thread |
| status_changed | output | 1 | Some thread reported a change last cycle |
| stage_active | output | 1 | Stage-level activity flag |
| squash_cancel | output | NT | Cancel pulse for each thread's outstanding request |

## Verification
Every result is registered, so state codes, `status_changed`, `squash_cancel` and `stage_active` all reflect the inputs applied in the cycle before one rising edge. The bench drives each input set at a falling edge and samples one time unit after the following rising edge. It clears the pulses before the next edge, so each check sees exactly one evaluation. Sticky flags carry across table rows on purpose, which lets the rows exercise stall persistence.

// File: rtl/fetchstat_pkg.sv
package fetchstat_pkg;
  localparam int unsigned STW  = 4;
  localparam int unsigned NSTG = 4;

  typedef enum logic [STW-1:0] {
    ST_RUN      = 4'd0,
    ST_IDLE     = 4'd1,
    ST_SQUASH   = 4'd2,
    ST_BLOCK    = 4'd3,
    ST_WAIT_RSP = 4'd4,
    ST_WAIT_RTY = 4'd5,
    ST_ACC_DONE = 4'd6,
    ST_TRAP_PND = 4'd7,
    ST_QUI_PND  = 4'd8
  } thr_state_e;
endpackage

// File: rtl/fs_stall_flags.sv
module fs_stall_flags
  import fetchstat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSTG-1:0] blk,
  input  logic [NSTG-1:0] unblk,
  input  logic            ctx_switch,
  output logic            stalled
);
  logic [NSTG-1:0] flags_q, flags_d;

  always_comb flags_d = (flags_q | blk) & ~unblk;
  assign stalled = ctx_switch | (|flags_d);

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // R11
  unblk_not_with_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk & unblk) == '0);
  // R11
  unblk_only_when_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unblk & ~flags_q) == '0);
endmodule

// File: rtl/fs_thread_fsm.sv
module fs_thread_fsm
  import fetchstat_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           cmt_sq,
  input  logic           rob_sq,
  input  logic           dec_sq,
  input  logic           stalled,
  input  logic           load,
  input  logic [STW-1:0] load_val,
  output thr_state_e     state_q,
  output thr_state_e     state_d,
  output logic           chg,
  output logic           cancel
);
  thr_state_e base;

  always_comb begin
    base    = load ? thr_state_e'(load_val) : state_q;
    state_d = base;
    chg     = 1'b0;
    cancel  = 1'b0;
    if (!active) begin
      state_d = state_q;
    end else if (cmt_sq) begin
      state_d = ST_SQUASH; chg = 1'b1; cancel = 1'b1;
    end else if (rob_sq) begin
      state_d = ST_SQUASH; chg = 1'b1;
    end else if (dec_sq && base != ST_SQUASH) begin
      state_d = ST_SQUASH; chg = 1'b1; cancel = 1'b1;
    end else if (stalled && base != ST_WAIT_RSP && base != ST_WAIT_RTY) begin
      state_d = ST_BLOCK; chg = 1'b1;
    end else if (base == ST_BLOCK || base == ST_SQUASH) begin
      state_d = ST_RUN; chg = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  // R3
  cmt_squash_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cmt_sq) |=> state_q == ST_SQUASH);
  // R6
  wait_rsp_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load && state_q == ST_WAIT_RSP && !cmt_sq && !rob_sq && !dec_sq)
      |=> state_q == ST_WAIT_RSP);
  // R10
  idle_thread_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(state_q));
endmodule

// File: rtl/fs_stage_activity.sv
module fs_stage_activity
  import fetchstat_pkg::*;
#(
  parameter int unsigned NT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NT-1:0]     active,
  input  logic [NT*STW-1:0] next_states,
  input  logic              any_chg,
  output logic              stage_active
);
  logic live;

  always_comb begin
    live = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (active[t] && (next_states[t*STW +: STW] == ST_RUN ||
                        next_states[t*STW +: STW] == ST_SQUASH ||
                        next_states[t*STW +: STW] == ST_ACC_DONE))
        live = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       stage_active <= 1'b1;
    else if (any_chg) stage_active <= live;
  end

  // R9
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_chg |=> $stable(stage_active));
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
  import fetchstat_pkg::*;
#(
  parameter int unsigned NT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NT-1:0]     thread_active,
  input  logic [NT-1:0]     dec_block,
  input  logic [NT-1:0]     dec_unblock,
  input  logic [NT-1:0]     ren_block,
  input  logic [NT-1:0]     ren_unblock,
  input  logic [NT-1:0]     exe_block,
  input  logic [NT-1:0]     exe_unblock,
  input  logic [NT-1:0]     cmt_block,
  input  logic [NT-1:0]     cmt_unblock,
  input  logic [NT-1:0]     cmt_squash,
  input  logic [NT-1:0]     rob_squashing,
  input  logic [NT-1:0]     dec_squash,
  input  logic              ctx_switch,
  input  logic [NT-1:0]     st_load,
  input  logic [NT*STW-1:0] st_load_val,
  output logic [NT*STW-1:0] thread_state,
  output logic              status_changed,
  output logic              stage_active,
  output logic [NT-1:0]     squash_cancel
);
  logic [NT-1:0]     chg_v, cancel_v, stalled_v;
  logic [NT*STW-1:0] next_v;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    thr_state_e sq, sd;

    fs_stall_flags u_flags (
      .clk(clk), .rst_n(rst_n),
      .blk({cmt_block[t], exe_block[t], ren_block[t], dec_block[t]}),
      .unblk({cmt_unblock[t], exe_unblock[t], ren_unblock[t], dec_unblock[t]}),
      .ctx_switch(ctx_switch),
      .stalled(stalled_v[t])
    );

    fs_thread_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .active(thread_active[t]),
      .cmt_sq(cmt_squash[t]), .rob_sq(rob_squashing[t]), .dec_sq(dec_squash[t]),
      .stalled(stalled_v[t]),
      .load(st_load[t]), .load_val(st_load_val[t*STW +: STW]),
      .state_q(sq), .state_d(sd),
      .chg(chg_v[t]), .cancel(cancel_v[t])
    );

    assign thread_state[t*STW +: STW] = sq;
    assign next_v[t*STW +: STW]       = sd;
  end

  fs_stage_activity #(.NT(NT)) u_act (
    .clk(clk), .rst_n(rst_n),
    .active(thread_active),
    .next_states(next_v),
    .any_chg(|chg_v),
    .stage_active(stage_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_changed <= 1'b0;
      squash_cancel  <= '0;
    end else begin
      status_changed <= |chg_v;
      squash_cancel  <= cancel_v;
    end
  end

  // R3
  cancel_means_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_cancel != '0) |-> status_changed);
endmodule

// File: tb/tb_fetch_status_ctrl.sv
module tb_fetch_status_ctrl;
  localparam int NT = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NT-1:0] act, db, du, rb, ru, eb, eu, cb, cu, csq, rsq, dsq, ld, cancel;
  logic ctx, chg, sact;
  logic [NT*4-1:0] lv, st;

  fetch_status_ctrl #(.NT(NT)) dut (
    .clk(clk), .rst_n(rst_n), .thread_active(act),
    .dec_block(db), .dec_unblock(du), .ren_block(rb), .ren_unblock(ru),
    .exe_block(eb), .exe_unblock(eu), .cmt_block(cb), .cmt_unblock(cu),
    .cmt_squash(csq), .rob_squashing(rsq), .dec_squash(dsq), .ctx_switch(ctx),
    .st_load(ld), .st_load_val(lv), .thread_state(st),
    .status_changed(chg), .stage_active(sact), .squash_cancel(cancel)
  );

  int total = 0, bad = 0;

  task automatic chk(input string req, input int a, input int e);
    total++;
    if (a != e) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  task automatic clr();
    db = '0; du = '0; rb = '0; ru = '0; eb = '0; eu = '0; cb = '0; cu = '0;
    csq = '0; rsq = '0; dsq = '0; ld = '0; lv = '0; ctx = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // block/unblock bits: [3]=commit [2]=execute [1]=rename [0]=decode
  typedef struct packed {
    logic ld; logic [3:0] lv; logic cm, rb, dc;
    logic [3:0] bk, ub; logic cx; logic [3:0] es; logic ec, en;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,4'h0,1'b0,1'b0}, // R8 idle run
    '{1'b0,4'h0,1'b0,1'b0,1'b0,4'h1,4'h0,1'b0,4'h3,1'b1,1'b0}, // R2 decode block
    '{1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,4'h3,1'b1,1'b0}, // R2 sticky
    '{1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h1,1'b0,4'h0,1'b1,1'b0}, // R11 unblock
    '{1'b1,4'h4,1'b0,1'b0,1'b0,4'h2,4'h0,1'b0,4'h4,1'b0,1'b0}, // R6 wait rsp
    '{1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,4'h4,1'b0,1'b0}, // R6 held
    '{1'b1,4'h6,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,4'h3,1'b1,1'b0}, // R6 done->blk
    '{1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h2,1'b0,4'h0,1'b1,1'b0}, // R7
    '{1'b0,4'h0,1'b0,1'b0,1'b1,4'h0,4'h0,1'b0,4'h2,1'b1,1'b1}, // R5
    '{1'b0,4'h0,1'b0,1'b0,1'b1,4'h0,4'h0,1'b0,4'h0,1'b1,1'b0}, // R5 already sq
    '{1'b0,4'h0,1'b0,1'b1,1'b0,4'h0,4'h0,1'b0,4'h2,1'b1,1'b0}, // R4
    '{1'b0,4'h0,1'b0,1'b1,1'b1,4'h0,4'h0,1'b0,4'h2,1'b1,1'b0}, // R4 over dec
    '{1'b0,4'h0,1'b1,1'b0,1'b0,4'h4,4'h0,1'b0,4'h2,1'b1,1'b1}, // R3 over stall
    '{1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,4'h3,1'b1,1'b0}, // R2 exe flag
    '{1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h4,1'b1,4'h3,1'b1,1'b0}, // R2 ctx
    '{1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,4'h0,1'b1,1'b0}, // R7
    '{1'b1,4'h1,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,4'h1,1'b0,1'b0}, // R8 idle
    '{1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,4'h1,1'b0,1'b0}, // R8 held
    '{1'b1,4'h5,1'b0,1'b0,1'b0,4'h8,4'h0,1'b0,4'h5,1'b0,1'b0}, // R6 retry
    '{1'b1,4'h0,1'b0,1'b0,1'b0,4'h0,4'h8,1'b0,4'h0,1'b0,1'b0}, // R8 load run
    '{1'b1,4'h7,1'b1,1'b0,1'b0,4'h0,4'h0,1'b0,4'h2,1'b1,1'b1}, // R3 over trap
    '{1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,4'h0,1'b1,1'b0}  // R7
  };

  initial begin
    act = 2'b01; clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    // R1
    chk("R1 state0", st[3:0], 0);   chk("R1 state1", st[7:4], 0);
    chk("R1 active", sact, 1);      chk("R1 changed", chg, 0);
    chk("R1 cancel", cancel, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      clr();
      ld[0] = VEC[i].ld; lv[3:0] = VEC[i].lv;
      csq[0] = VEC[i].cm; rsq[0] = VEC[i].rb; dsq[0] = VEC[i].dc;
      db[0] = VEC[i].bk[0]; rb[0] = VEC[i].bk[1]; eb[0] = VEC[i].bk[2]; cb[0] = VEC[i].bk[3];
      du[0] = VEC[i].ub[0]; ru[0] = VEC[i].ub[1]; eu[0] = VEC[i].ub[2]; cu[0] = VEC[i].ub[3];
      ctx = VEC[i].cx;
      step();
      clr();
      chk($sformatf("vec%0d state", i), st[3:0], VEC[i].es);
      chk($sformatf("vec%0d changed", i), chg, VEC[i].ec);
      chk($sformatf("vec%0d cancel", i), cancel[0], VEC[i].en);
      chk($sformatf("R10 vec%0d thread1 hold", i), st[7:4], 0);
    end

    // R10: inactive thread ignores commit squash and load
    @(negedge clk); csq[1] = 1'b1; ld[1] = 1'b1; lv[7:4] = 4'h7; step(); clr();
    chk("R10 inactive state", st[7:4], 0);
    chk("R10 no change", chg, 0);

    // R9: loads without change keep stage_active
    @(negedge clk); act = 2'b11; ld = 2'b11; lv = {4'h4, 4'h1}; step(); clr();
    chk("R9 held state1", st[7:4], 4);
    chk("R9 no reeval", sact, 1);
    // R9: change with no live thread -> inactive
    @(negedge clk); db[0] = 1'b1; step(); clr();
    chk("R9 blocked0", st[3:0], 3);
    chk("R9 inactive", sact, 0);
    // R9: thread1 decode squash makes stage live again
    @(negedge clk); dsq[1] = 1'b1; du[0] = 1'b1; step(); clr();
    chk("R9 thread1 squash", st[7:4], 2);
    chk("R9 active again", sact, 1);
    chk("R5 cancel thread1", cancel, 2'b10);

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0; step(); rst_n = 1'b1;
    chk("R1 re-reset state1", st[7:4], 0);
    chk("R1 re-reset active", sact, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule